// File: doc/BRIEF.md
# Processor Interrupt Exception Controller

This block is the interrupt half of a system control coprocessor in a scalar in-order core. It collects eight interrupt sources: two pending bits that software sets and clears, five hardware request lines and one timer line. It holds the per-source enable mask and the global controls, which are an enable bit and two exception-level bits that block interrupts. Every cycle it decides whether the instruction now presented by the pipeline is interrupted.

When it takes an interrupt it records four things in one clock edge: the interrupted address (or the address of the branch before it, when the instruction sits in a delay slot), the branch-delay flag, the interrupt exception code, and a raised exception level. In the following cycle it emits a one-cycle fetch redirect to the common exception vector.

Software reaches the status, cause and exception-PC registers through a single-cycle register port. Reads are combinational, so the pending field reflects the request lines as they are in the current cycle.

Top module: `intr_exc_ctrl`

## Requirements
- R1: After reset the status (select 0), cause (select 1) and exception-PC (select 2) registers all read 0, and `redirect_o` is 0.
- R2: Cause bits 15:8 form the pending field. Bits 9:8 are the two software bits, bits 13:10 follow `hw_int_i[3:0]`, bit 15 follows `timer_int_i`, and bit 14 always reads 0 and can never cause a take, whatever `hw_int_i[4]` does.
- R3: The hardware and timer pending bits follow their request lines in the same cycle, and clear as soon as the line drops, without any write.
- R4: A pending source whose mask bit is 0 never causes a take. The mask bits are status bits 15:8, in the same positions as the pending bits.
- R5: No interrupt is taken while status bit 0 (global enable) is 0, bit 1 (exception level) is 1, or bit 2 (error level) is 1.
- R6: Suppose that at a clock edge `pc_valid_i` is 1, the global enable bit is 1, both level bits are 0, and some pending bit has its mask bit set. The interrupt is then taken at that edge. After the edge, `redirect_o` is 1 and `redirect_pc_o` equals the vector base plus 0x180 (0x8000_0180 by default). The cause exception-code field (bits 6:2) is 0. The exception PC holds `pc_i`, and cause bit 31 (BD) is 0. With `pc_valid_i` at 0, nothing is taken.
- R7: A take with `in_slot_i` high stores `pc_i - 4` in the exception PC and sets cause bit 31 to 1.
- R8: A take sets the exception-level bit at the same edge. `redirect_o` is high for exactly one cycle, and no further take happens until software clears the exception level, even while the request line stays high.
- R9: Software pending bits change only through a cause write, which loads them from write-data bits 9:8. They hold their value otherwise. A cause write leaves BD, the exception code and the hardware pending bits unchanged.
- R10: When a status write and a take happen at the same edge, the mask and global enable take the written values and the exception-level bit ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_int_i | input | 5 | Hardware request lines; line 4 is tied off inside |
| timer_int_i | input | 1 | Timer request line |
| pc_i | input | 32 | Address of the instruction now at the interrupt point |
| pc_valid_i | input | 1 | `pc_i` names a real instruction that may be interrupted |
| in_slot_i | input | 1 | That instruction is in a branch delay slot |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 status, 1 cause, 2 exception PC |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| redirect_o | output | 1 | One-cycle fetch redirect to the exception vector |
| redirect_pc_o | output | 32 | Common exception vector address |

## Verification
The bench drives the tied-off fifth hardware line with every mask bit open. A design that mapped that line through would show bit 14 pending and take an interrupt. It then holds a request line high across a take. A design that failed to raise the exception level at the take edge would produce a second redirect pulse. For a delay-slot take, the bench checks that the exception PC moves back one instruction and that BD is set, which catches designs that store the slot address itself. It also lands a status write on the same edge as a take, where a design that let the write win would leave the exception level clear and reopen the interrupt. A cause write that sets every field bit checks that BD and the exception code cannot be written by software.

// File: rtl/intr_exc_pkg.sv
package intr_exc_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned N_IRQ  = 8;
  localparam int unsigned N_SW   = 2;
  localparam int unsigned N_HW   = 5;
  localparam int unsigned IRQ_LSB = 8;  // pending/mask field base in cause/status
  localparam int unsigned BD_BIT  = 31;
  localparam int unsigned CODE_LSB = 2;
  localparam int unsigned CODE_W   = 5;
  localparam logic [CODE_W-1:0] CODE_INT = '0;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_CAUSE  = 2'd1,
    SEL_EPC    = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  function automatic logic [XLEN-1:0] pack_status(
    input logic [N_IRQ-1:0] im, input logic ie, input logic exl, input logic erl);
    logic [XLEN-1:0] v;
    v = '0;
    v[IRQ_LSB +: N_IRQ] = im;
    v[0] = ie;
    v[1] = exl;
    v[2] = erl;
    return v;
  endfunction

  function automatic logic [XLEN-1:0] pack_cause(
    input logic bd, input logic [N_IRQ-1:0] ip, input logic [CODE_W-1:0] code);
    logic [XLEN-1:0] v;
    v = '0;
    v[BD_BIT] = bd;
    v[IRQ_LSB +: N_IRQ] = ip;
    v[CODE_LSB +: CODE_W] = code;
    return v;
  endfunction
endpackage

// File: rtl/intr_src.sv
module intr_src
  import intr_exc_pkg::*;
#(
  parameter int unsigned TIED_IDX = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_HW-1:0]  hw_int_i,
  input  logic             timer_i,
  input  logic             sw_we_i,
  input  logic [N_SW-1:0]  sw_wdata_i,
  output logic [N_IRQ-1:0] ip_o
);
  localparam logic [N_HW-1:0] LIVE_MASK = ~(N_HW'(1) << TIED_IDX);

  logic [N_SW-1:0] sw_q;
  logic [N_HW-1:0] hw_pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sw_q <= '0;
    else if (sw_we_i) sw_q <= sw_wdata_i;
  end

  // hardware pending is level-following, not latched
  assign hw_pend = hw_int_i & LIVE_MASK;
  assign ip_o    = {timer_i, hw_pend, sw_q};

  AST_SW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_we_i |=> $stable(sw_q)); // R9
  AST_SW_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_we_i |=> sw_q == $past(sw_wdata_i)); // R9
endmodule

// File: rtl/intr_status.sv
module intr_status
  import intr_exc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [N_IRQ-1:0] im_wdata_i,
  input  logic [2:0]       ctl_wdata_i,  // {erl, exl, ie}
  input  logic             take_i,
  output logic [N_IRQ-1:0] im_o,
  output logic             ie_o,
  output logic             exl_o,
  output logic             erl_o,
  output logic             gate_o
);
  logic [N_IRQ-1:0] im_q;
  logic ie_q, exl_q, erl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      im_q  <= '0;
      ie_q  <= 1'b0;
      exl_q <= 1'b0;
      erl_q <= 1'b0;
    end else begin
      if (wr_i) begin
        im_q  <= im_wdata_i;
        ie_q  <= ctl_wdata_i[0];
        exl_q <= ctl_wdata_i[1];
        erl_q <= ctl_wdata_i[2];
      end
      // take wins over a concurrent write for the level bit
      if (take_i) exl_q <= 1'b1;
    end
  end

  assign im_o   = im_q;
  assign ie_o   = ie_q;
  assign exl_o  = exl_q;
  assign erl_o  = erl_q;
  assign gate_o = ie_q & ~exl_q & ~erl_q;

  AST_EXL_ON_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> exl_q); // R8
  AST_WR_TAKE_MERGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && wr_i) |=> (exl_q && im_q == $past(im_wdata_i) && ie_q == $past(ctl_wdata_i[0]))); // R10
endmodule

// File: rtl/intr_capture.sv
module intr_capture
  import intr_exc_pkg::*;
#(
  parameter int unsigned INSTR_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IRQ-1:0]  ip_i,
  input  logic [N_IRQ-1:0]  im_i,
  input  logic              gate_i,
  input  logic              pc_valid_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              slot_i,
  input  logic              epc_we_i,
  input  logic [XLEN-1:0]   epc_wdata_i,
  output logic              take_o,
  output logic [XLEN-1:0]   epc_o,
  output logic              bd_o,
  output logic [CODE_W-1:0] code_o,
  output logic              redirect_o
);
  logic [XLEN-1:0]   epc_q;
  logic              bd_q, redir_q;
  logic [CODE_W-1:0] code_q;
  logic [XLEN-1:0]   epc_nxt;

  assign take_o  = gate_i & pc_valid_i & (|(ip_i & im_i));
  assign epc_nxt = slot_i ? (pc_i - XLEN'(INSTR_BYTES)) : pc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epc_q   <= '0;
      bd_q    <= 1'b0;
      code_q  <= '0;
      redir_q <= 1'b0;
    end else begin
      redir_q <= take_o;
      if (take_o) begin
        epc_q  <= epc_nxt;
        bd_q   <= slot_i;
        code_q <= CODE_INT;
      end else if (epc_we_i) begin
        epc_q  <= epc_wdata_i;
      end
    end
  end

  assign epc_o      = epc_q;
  assign bd_o       = bd_q;
  assign code_o     = code_q;
  assign redirect_o = redir_q;

  AST_SLOT_REWIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && slot_i) |=> (bd_q && epc_q == $past(pc_i) - XLEN'(INSTR_BYTES))); // R7
  AST_PLAIN_EPC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && !slot_i) |=> (!bd_q && epc_q == $past(pc_i))); // R6
  AST_REDIR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_q |=> !redir_q); // R8
endmodule

// File: rtl/intr_exc_ctrl.sv
module intr_exc_ctrl
  import intr_exc_pkg::*;
#(
  parameter logic [31:0] VEC_BASE    = 32'h8000_0000,
  parameter logic [31:0] VEC_OFS     = 32'h0000_0180,
  parameter int unsigned TIED_IDX    = 4,
  parameter int unsigned INSTR_BYTES = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [4:0]  hw_int_i,
  input  logic        timer_int_i,
  input  logic [31:0] pc_i,
  input  logic        pc_valid_i,
  input  logic        in_slot_i,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_sel_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        redirect_o,
  output logic [31:0] redirect_pc_o
);
  reg_sel_e sel;
  logic [N_IRQ-1:0]  ip, im;
  logic              ie, exl, erl, gate, take, bd;
  logic [XLEN-1:0]   epc;
  logic [CODE_W-1:0] code;
  logic              wr_status, wr_cause, wr_epc;

  assign sel       = reg_sel_e'(reg_sel_i);
  assign wr_status = reg_we_i && (sel == SEL_STATUS);
  assign wr_cause  = reg_we_i && (sel == SEL_CAUSE);
  assign wr_epc    = reg_we_i && (sel == SEL_EPC);

  intr_src #(.TIED_IDX(TIED_IDX)) u_src (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hw_int_i   (hw_int_i),
    .timer_i    (timer_int_i),
    .sw_we_i    (wr_cause),
    .sw_wdata_i (reg_wdata_i[IRQ_LSB +: N_SW]),
    .ip_o       (ip)
  );

  intr_status u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_status),
    .im_wdata_i  (reg_wdata_i[IRQ_LSB +: N_IRQ]),
    .ctl_wdata_i (reg_wdata_i[2:0]),
    .take_i      (take),
    .im_o        (im),
    .ie_o        (ie),
    .exl_o       (exl),
    .erl_o       (erl),
    .gate_o      (gate)
  );

  intr_capture #(.INSTR_BYTES(INSTR_BYTES)) u_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ip_i        (ip),
    .im_i        (im),
    .gate_i      (gate),
    .pc_valid_i  (pc_valid_i),
    .pc_i        (pc_i),
    .slot_i      (in_slot_i),
    .epc_we_i    (wr_epc),
    .epc_wdata_i (reg_wdata_i),
    .take_o      (take),
    .epc_o       (epc),
    .bd_o        (bd),
    .code_o      (code),
    .redirect_o  (redirect_o)
  );

  always_comb begin
    unique case (sel)
      SEL_STATUS: reg_rdata_o = pack_status(im, ie, exl, erl);
      SEL_CAUSE:  reg_rdata_o = pack_cause(bd, ip, code);
      SEL_EPC:    reg_rdata_o = epc;
      default:    reg_rdata_o = '0;
    endcase
  end

  assign redirect_pc_o = VEC_BASE + VEC_OFS;

  AST_REDIR_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> $past(ie && !erl && pc_valid_i && (|(ip & im)))); // R5
  AST_REDIR_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> exl); // R8
  AST_TIED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ip[N_SW +: N_HW] == '0 && !ip[N_IRQ-1] && ip[N_SW-1:0] == '0) |=> !redirect_o); // R2
endmodule

// File: tb/intr_exc_ctrl_tb_top.sv
module intr_exc_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  hw_int_i = '0;
  logic        timer_int_i = 1'b0;
  logic [31:0] pc_i = '0;
  logic        pc_valid_i = 1'b0;
  logic        in_slot_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_sel_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        redirect_o;
  logic [31:0] redirect_pc_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  intr_exc_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .hw_int_i(hw_int_i), .timer_int_i(timer_int_i),
    .pc_i(pc_i), .pc_valid_i(pc_valid_i), .in_slot_i(in_slot_i),
    .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o)
  );

  localparam logic [1:0] S_ST = 2'd0, S_CA = 2'd1, S_EPC = 2'd2;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [1:0] sel, input logic [31:0] exp);
    reg_sel_i = sel;
    #0.5;
    check(req, reg_rdata_o, exp);
  endtask

  task automatic watch_quiet(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      check(req, {31'd0, redirect_o}, 32'd0);
    end
  endtask

  task automatic t_reset();
    check("R1 redirect", {31'd0, redirect_o}, 32'd0);
    rd_check("R1 status", S_ST, 32'h0);
    rd_check("R1 cause", S_CA, 32'h0);
    rd_check("R1 epc", S_EPC, 32'h0);
  endtask

  task automatic t_map();
    @(negedge clk_i);
    hw_int_i = 5'b11111; timer_int_i = 1'b1;
    rd_check("R2 pending map", S_CA, 32'h0000_BC00);
    hw_int_i = 5'b00000; timer_int_i = 1'b0;
    rd_check("R3 pending drop", S_CA, 32'h0);
    hw_int_i = 5'b00100;
    rd_check("R3 pending follow", S_CA, 32'h0000_1000);
    hw_int_i = '0;
  endtask

  task automatic t_sw();
    wr(S_CA, 32'h0000_0300);
    rd_check("R9 sw set", S_CA, 32'h0000_0300);
    wr(S_CA, 32'h8000_017C);
    rd_check("R9 ro fields", S_CA, 32'h0000_0100);
    repeat (3) @(negedge clk_i);
    rd_check("R9 sw hold", S_CA, 32'h0000_0100);
    wr(S_CA, 32'h0);
    rd_check("R9 sw clear", S_CA, 32'h0);
  endtask

  task automatic t_mask();
    pc_valid_i = 1'b1; pc_i = 32'h0000_0400;
    wr(S_ST, 32'h0000_FB01);
    hw_int_i = 5'b00001;
    watch_quiet("R4 masked", 3);
    hw_int_i = '0;
    wr(S_ST, 32'h0000_FF01);
    hw_int_i = 5'b10000;
    rd_check("R2 tied line", S_CA, 32'h0);
    watch_quiet("R2 tied no take", 3);
    hw_int_i = '0;
  endtask

  task automatic t_global();
    wr(S_ST, 32'h0000_FF00);
    hw_int_i = 5'b00001;
    watch_quiet("R5 ie clear", 3);
    hw_int_i = '0;
    wr(S_ST, 32'h0000_FF03);
    hw_int_i = 5'b00001;
    watch_quiet("R5 exl set", 3);
    hw_int_i = '0;
    wr(S_ST, 32'h0000_FF05);
    hw_int_i = 5'b00001;
    watch_quiet("R5 erl set", 3);
    hw_int_i = '0;
    pc_valid_i = 1'b0;
    wr(S_ST, 32'h0000_FF01);
    hw_int_i = 5'b00001;
    watch_quiet("R6 no valid pc", 3);
    hw_int_i = '0;
  endtask

  task automatic t_take();
    wr(S_ST, 32'h0000_FF01);
    pc_i = 32'h0000_1000; pc_valid_i = 1'b1; in_slot_i = 1'b0;
    hw_int_i = 5'b00010;
    @(negedge clk_i);
    check("R6 redirect", {31'd0, redirect_o}, 32'd1);
    check("R6 vector", redirect_pc_o, 32'h8000_0180);
    rd_check("R6 epc", S_EPC, 32'h0000_1000);
    rd_check("R6 cause", S_CA, 32'h0000_0800);
    rd_check("R8 exl set", S_ST, 32'h0000_FF03);
    watch_quiet("R8 one pulse", 3);
    hw_int_i = '0;
    wr(S_ST, 32'h0000_FF01);
    watch_quiet("R8 no stale take", 2);
  endtask

  task automatic t_slot();
    wr(S_ST, 32'h0000_0101);
    pc_i = 32'h0000_2004; in_slot_i = 1'b1; pc_valid_i = 1'b1;
    wr(S_CA, 32'h0000_0100);
    @(negedge clk_i);
    check("R7 redirect", {31'd0, redirect_o}, 32'd1);
    rd_check("R7 epc", S_EPC, 32'h0000_2000);
    rd_check("R7 bd", S_CA, 32'h8000_0100);
    in_slot_i = 1'b0;
    wr(S_CA, 32'h0);
    rd_check("R9 bd kept", S_CA, 32'h8000_0000);
    wr(S_ST, 32'h0000_0101);
    watch_quiet("R9 sw cleared", 2);
  endtask

  task automatic t_merge();
    pc_valid_i = 1'b0;
    wr(S_ST, 32'h0000_FF01);
    wr(S_CA, 32'h0000_0100);
    @(negedge clk_i);
    pc_valid_i = 1'b1; pc_i = 32'h0000_3000;
    reg_we_i = 1'b1; reg_sel_i = S_ST; reg_wdata_i = 32'h0000_7F01;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    check("R10 redirect", {31'd0, redirect_o}, 32'd1);
    rd_check("R10 status", S_ST, 32'h0000_7F03);
    rd_check("R10 epc", S_EPC, 32'h0000_3000);
    rd_check("R10 cause", S_CA, 32'h0000_0100);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_map();
    t_sw();
    t_mask();
    t_global();
    t_take();
    t_slot();
    t_merge();
    summary();
  end
endmodule